// File: doc/BRIEF.md
# Delta-Compressed Branch Address Packetizer

This block turns a 32-bit branch target address into a short run of bytes on a byte stream that uses a ready/valid handshake. The address is cut into 7-bit groups, lowest first. Each byte carries one group in its low seven bits. Bit 7 is a flag that says another byte follows. Only the groups up to the highest one that differs from the last address sent go out. A receiver that keeps the previous address can then rebuild the full value from the low bytes it gets.

The fifth byte is special. It holds the top four address bits, a one-bit state flag and a two-bit reason code. The block must send the full five-byte form for the first address after reset, and whenever the `in_full` request comes with an address. The receiver has no reference value until it sees a full form. The block stores the last address it sent as the reference for the next delta. It updates that reference only when the final byte of a sequence has been taken. It accepts a new address only after the current sequence has fully drained.

Top module: `addr_packetizer`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0, and the first address accepted after reset is sent as five bytes.
- R2: In every byte except the last of a sequence, bit 7 is 1. In the last byte, bit 7 is 0.
- R3: Byte k of a sequence (k = 0..3, in the order sent) carries address bits [7k+6:7k] in its bits [6:0].
- R4: The fifth byte carries address bits [31:28] in bits [3:0], the state flag in bit 4, the reason code in bits [6:5], and 0 in bit 7.
- R5: When no full form is due, the number of bytes is one more than the index of the highest 7-bit group in which the new address differs from the reference. Group 4 covers bits [31:28]. An identical address gives one byte.
- R6: An address accepted with `in_full` = 1 is sent as five bytes, whatever the reference holds.
- R7: `in_ready` is 0 while any byte of the current sequence is still unsent. An `in_valid` during that time is ignored and does not change the bytes being sent.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_byte` holds steady. The reference changes only on the cycle the final byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New address offered |
| in_ready | output | 1 | Block can accept an address |
| in_addr | input | 32 | Branch target address |
| in_reason | input | 2 | Reason code placed in the fifth byte |
| in_state | input | 1 | State flag placed in the fifth byte |
| in_full | input | 1 | Request the full five-byte form |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Packet byte |

## Verification
The hardest case to reach is a change confined to one group, such as bits [31:28] alone or bit 27 alone, while the reference holds a known value. Purely random addresses almost always differ in the top group and so give five bytes every time. The stimulus therefore builds most new addresses from the previous one, by leaving it unchanged or flipping a single bit inside a chosen group. It also drives directed flips at group edges. While doing this it stalls `out_ready` at random and offers junk addresses while the block is busy, so the reference-update and ignore rules are exercised under backpressure.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
    localparam int DEF_ADDR_W   = 32;
    localparam int DEF_GRP_W    = 7;
    localparam int DEF_NUM_GRP  = 5;
    localparam int DEF_REASON_W = 2;
endpackage

// File: rtl/pkt_group_sizer.sv
module pkt_group_sizer #(
    parameter int ADDR_W  = pkt_pkg::DEF_ADDR_W,
    parameter int GRP_W   = pkt_pkg::DEF_GRP_W,
    parameter int NUM_GRP = pkt_pkg::DEF_NUM_GRP,
    parameter int CNT_W   = $clog2(NUM_GRP + 1)
) (
    input  logic [ADDR_W-1:0] diff,
    output logic [CNT_W-1:0]  count
);
    logic [NUM_GRP-1:0] grp_nz;

    genvar g;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam int LO = g * GRP_W;
            localparam int HI = ((g + 1) * GRP_W - 1 < ADDR_W) ? (g + 1) * GRP_W - 1 : ADDR_W - 1;
            assign grp_nz[g] = |diff[HI:LO];
        end
    endgenerate

    always_comb begin
        count = CNT_W'(1);
        for (int i = 1; i < NUM_GRP; i++) begin
            if (grp_nz[i]) count = CNT_W'(i + 1);
        end
    end

    always_comb begin
        AST_COUNT_RANGE: assert (count >= CNT_W'(1) && count <= CNT_W'(NUM_GRP)); // R5
    end
endmodule

// File: rtl/pkt_byte_former.sv
module pkt_byte_former #(
    parameter int ADDR_W   = pkt_pkg::DEF_ADDR_W,
    parameter int GRP_W    = pkt_pkg::DEF_GRP_W,
    parameter int NUM_GRP  = pkt_pkg::DEF_NUM_GRP,
    parameter int REASON_W = pkt_pkg::DEF_REASON_W,
    parameter int CNT_W    = $clog2(NUM_GRP + 1)
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CNT_W-1:0]    idx,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [REASON_W-1:0] reason,
    input  logic                state,
    output logic [GRP_W:0]      byte_o
);
    localparam int TOP_W = ADDR_W - GRP_W * (NUM_GRP - 1);

    logic [ADDR_W-1:0] shifted;

    always_comb begin
        shifted = addr >> (GRP_W * int'(idx));
        if (idx == CNT_W'(NUM_GRP - 1)) begin
            byte_o = {1'b0, reason, state, addr[ADDR_W-1 -: TOP_W]};
        end else begin
            byte_o = {(idx != cnt - CNT_W'(1)), shifted[GRP_W-1:0]};
        end
    end
endmodule

// File: rtl/addr_packetizer.sv
module addr_packetizer #(
    parameter int ADDR_W   = pkt_pkg::DEF_ADDR_W,
    parameter int GRP_W    = pkt_pkg::DEF_GRP_W,
    parameter int NUM_GRP  = pkt_pkg::DEF_NUM_GRP,
    parameter int REASON_W = pkt_pkg::DEF_REASON_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_addr,
    input  logic [REASON_W-1:0] in_reason,
    input  logic                in_state,
    input  logic                in_full,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [GRP_W:0]      out_byte
);
    localparam int CNT_W = $clog2(NUM_GRP + 1);

    typedef struct packed {
        logic                busy;
        logic                need_full;
        logic [CNT_W-1:0]    idx;
        logic [CNT_W-1:0]    cnt;
        logic [ADDR_W-1:0]   addr;
        logic [ADDR_W-1:0]   prev;
        logic [REASON_W-1:0] reason;
        logic                state;
    } pk_state_t;

    pk_state_t st_q, st_d;
    logic [CNT_W-1:0] delta_cnt;
    logic             accept;
    logic             fire;
    logic             last;

    pkt_group_sizer #(
        .ADDR_W(ADDR_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP), .CNT_W(CNT_W)
    ) u_sizer (
        .diff  (in_addr ^ st_q.prev),
        .count (delta_cnt)
    );

    pkt_byte_former #(
        .ADDR_W(ADDR_W), .GRP_W(GRP_W), .NUM_GRP(NUM_GRP),
        .REASON_W(REASON_W), .CNT_W(CNT_W)
    ) u_former (
        .addr   (st_q.addr),
        .idx    (st_q.idx),
        .cnt    (st_q.cnt),
        .reason (st_q.reason),
        .state  (st_q.state),
        .byte_o (out_byte)
    );

    assign in_ready  = !st_q.busy;
    assign out_valid = st_q.busy;
    assign accept    = in_valid && in_ready;
    assign fire      = out_valid && out_ready;
    assign last      = (st_q.idx == st_q.cnt - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy      = 1'b1;
            st_d.need_full = 1'b0;
            st_d.idx       = '0;
            st_d.cnt       = (st_q.need_full || in_full) ? CNT_W'(NUM_GRP) : delta_cnt;
            st_d.addr      = in_addr;
            st_d.reason    = in_reason;
            st_d.state     = in_state;
        end else if (fire) begin
            if (last) begin
                st_d.busy = 1'b0;
                st_d.prev = st_q.addr;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.need_full <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_BUSY_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7

    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R8

    AST_LAST_NO_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && last) |-> !out_byte[GRP_W]); // R2

    AST_REF_ON_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.prev) |-> $past(fire && last)); // R8

    AST_FULL_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_full) |=> (st_q.cnt == CNT_W'(NUM_GRP))); // R6
endmodule

// File: tb/addr_packetizer_bench.sv
module addr_packetizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic [1:0]  in_reason = '0;
    logic        in_state = 1'b0;
    logic        in_full = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [31:0] prev_m = '0;
    bit          need_full_m = 1'b1;

    addr_packetizer u_addr_packetizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_reason(in_reason), .in_state(in_state),
        .in_full(in_full), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_count(input logic [31:0] d);
        int c = 1;
        for (int g = 1; g < 5; g++) if ((d >> (7 * g)) != 0) c = g + 1;
        return c;
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] a, input logic [1:0] r,
                                            input logic s, input int n, input int k);
        logic [31:0] sh;
        if (k == 4) return {1'b0, r, s, a[31:28]};
        sh = a >> (7 * k);
        return {(k != n - 1), sh[6:0]};
    endfunction

    task automatic send(input logic [31:0] a, input logic [1:0] r, input logic s,
                        input logic f, input bit junk, input string req);
        int n;
        int got = 0;
        int guard = 0;
        bit held = 1'b0;
        logic [7:0] held_byte = '0;
        n = (need_full_m || f) ? 5 : exp_count(a ^ prev_m);
        @(negedge clk);
        chk(in_ready === 1'b1, "R7 ready when idle", {31'b0, in_ready}, 32'd1);
        in_valid = 1'b1; in_addr = a; in_reason = r; in_state = s; in_full = f;
        @(negedge clk);
        in_valid = 1'b0; in_full = 1'b0;
        while (got < n && guard < 2000) begin
            if (held) chk(out_byte === held_byte, "R8 byte held under stall", {24'b0, out_byte}, {24'b0, held_byte});
            out_ready = ($urandom % 4) != 0;
            if (junk) begin
                in_valid = $urandom % 2;
                in_addr  = $urandom;
                in_full  = $urandom % 2;
            end
            chk(out_valid === 1'b1, "R7 valid while bytes remain", {31'b0, out_valid}, 32'd1);
            chk(in_ready === 1'b0, "R7 not ready while busy", {31'b0, in_ready}, 32'd0);
            held = 1'b0;
            if (out_valid && out_ready) begin
                chk(out_byte === exp_byte(a, r, s, n, got), req, {24'b0, out_byte},
                    {24'b0, exp_byte(a, r, s, n, got)});
                got++;
            end else begin
                held = 1'b1;
                held_byte = out_byte;
            end
            @(negedge clk);
            guard++;
        end
        in_valid = 1'b0; in_full = 1'b0; out_ready = 1'b0;
        chk(got == n, "R5 byte count", got, n);
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R7 idle after last byte",
            {30'b0, out_valid, in_ready}, 32'd1);
        prev_m = a;
        need_full_m = 1'b0;
    endtask

    initial begin
        logic [31:0] a;
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset state",
            {30'b0, in_ready, out_valid}, 32'd2);
        // R1: first address after reset goes out in full, even if equal to the zero reference
        send(32'h0000_0000, 2'd2, 1'b1, 1'b0, 1'b0, "R1 R3 R4 first full");
        // R5 identical address gives one byte
        send(32'h0000_0000, 2'd1, 1'b0, 1'b0, 1'b0, "R5 R2 same address");
        // R4/R5 change only bits [31:28]
        send(32'h1000_0000, 2'd3, 1'b1, 1'b0, 1'b0, "R4 R5 top group");
        // R5 bit 27 gives four bytes
        send(32'h1800_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R5 R3 bit27");
        // R5 bit 7 gives two bytes
        send(32'h1800_0080, 2'd0, 1'b0, 1'b0, 1'b0, "R5 R2 bit7");
        // R6 forced full despite identical address
        send(32'h1800_0080, 2'd3, 1'b1, 1'b1, 1'b0, "R6 forced full");
        // R7 junk offered while busy
        send(32'h0abc_1234, 2'd1, 1'b1, 1'b0, 1'b1, "R7 ignore while busy");
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 5)
                0: a = prev_m;
                1: a = prev_m ^ (32'd1 << ($urandom % 32));
                2: a = prev_m ^ (32'd1 << ($urandom % 7));
                3: a = prev_m ^ (32'd1 << (7 * ($urandom % 5)));
                default: a = $urandom;
            endcase
            send(a, 2'($urandom), 1'($urandom), ($urandom % 10) == 0, ($urandom % 3) == 0,
                 "R2 R3 R4 R5 R8 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule